// File: doc/BRIEF.md
# GF(4096) Syndrome Generator

This block computes a set of Reed–Solomon syndromes over GF(2^12) for a stream of 12-bit code symbols. The field multiply is built as a tower: GF(64) is reduced by x^6 + x + 1, and GF(4096) is a quadratic extension of it. Each 12-bit element has a 6-bit high half and a 6-bit low half. The code's primitive element is 0x0E01, and syndrome i uses the root alpha^i, with i counted from zero.

A start pulse opens a codeword and clears every syndrome. Symbols then arrive one per valid cycle, and each accumulator takes a Horner step. The symbol flagged as last closes the codeword. One cycle after that symbol the block pulses done and shows the packed syndromes, two per 32-bit word. A flag reports whether any syndrome is nonzero, which means the codeword needs correction. Turning bytes into symbols and solving the key equation are handled elsewhere.

Top module: `gf4k_syndrome_gen`

## Requirements
- R1: After reset, all syndrome words are zero and done and nonzero are low.
- R2: GF(64) products are reduced modulo x^6 + x + 1. When bit 6 appears during a shift step it is cleared and the value is XORed with 0x43.
- R3: A GF(4096) product of a={ah,al} and b={bh,bl} has high half (ah^al)(bh^bl) ^ al·bl and low half ah·bh·0x21 ^ al·bl. The high half is bits [11:6] and the low half is bits [5:0].
- R4: Syndrome i uses the root alpha^i, where alpha = 0x0E01 and alpha^0 = 1. On each valid symbol it updates as S_i <= S_i·alpha^i ^ symbol.
- R5: A start pulse clears every syndrome. A valid symbol in the same cycle as start becomes the first symbol of the new codeword.
- R6: Cycles with neither start nor a valid symbol leave all syndromes unchanged.
- R7: done is high for exactly the cycle after a valid symbol flagged as last, and low at all other times.
- R8: nonzero is high exactly when at least one syndrome is nonzero.
- R9: Word k of syn_words occupies bits [32k+31:32k]. It holds syndrome 2k in bits [11:0] and syndrome 2k+1 in bits [27:16]. Bits [15:12] and [31:28] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the syndromes and opens a codeword |
| sym_valid | input | 1 | sym_data carries a symbol this cycle |
| sym_last | input | 1 | The valid symbol this cycle is the last of the codeword |
| sym_data | input | 12 | Code symbol |
| done | output | 1 | One-cycle pulse after the last symbol is taken |
| nonzero | output | 1 | At least one syndrome is nonzero |
| syn_words | output | NSYN*16 | Packed syndromes, two per 32-bit word |

## Verification
The multiplier is buried inside the accumulators, so a product cannot be seen directly at the ports. The hardest case to reach is therefore every operand pairing of the tower multiply against each fixed root. The bench gets there by sending, for every one of the 4096 symbol values, a two-symbol codeword: the value, then zero. After that codeword each syndrome equals the value times alpha^i, which exposes each root product for the whole field. Longer codewords then add idle gaps, a start that arrives with a symbol, and a start alone in mid-codeword.

// File: rtl/gf4k_syndrome_gen.sv
module gf4k_syndrome_gen #(
  parameter int NSYN = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                sym_valid,
  input  logic                sym_last,
  input  logic [11:0]         sym_data,
  output logic                done,
  output logic                nonzero,
  output logic [NSYN*16-1:0]  syn_words
);

  localparam logic [11:0] ALPHA = 12'h0E01;

  // R2: shift-and-add in GF(64), fold bit 6 with 0x43
  function automatic logic [5:0] gf64_mul(input logic [5:0] a, input logic [5:0] b);
    logic [6:0] sh;
    logic [5:0] acc;
    sh  = {1'b0, b};
    acc = '0;
    for (int k = 0; k < 6; k++) begin
      if (a[k]) acc = acc ^ sh[5:0];
      sh = sh << 1;
      if (sh[6]) sh = sh ^ 7'h43;
    end
    return acc;
  endfunction

  // R3: quadratic extension over GF(64)
  function automatic logic [11:0] gf4k_mul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] lo_prod, hi, lo;
    lo_prod = gf64_mul(a[5:0], b[5:0]);
    hi = gf64_mul(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo_prod;
    lo = gf64_mul(gf64_mul(a[11:6], b[11:6]), 6'h21) ^ lo_prod;
    return {hi, lo};
  endfunction

  function automatic logic [11:0] gf4k_pow(input int n);
    logic [11:0] r;
    r = 12'h001;
    for (int k = 0; k < n; k++) r = gf4k_mul(r, ALPHA);
    return r;
  endfunction

  logic [NSYN-1:0] nz_bits;
  logic            take;
  logic [11:0]     feed;

  assign take = start | sym_valid;
  assign feed = sym_valid ? sym_data : 12'h000;

  for (genvar i = 0; i < NSYN; i++) begin : g_syn
    localparam logic [11:0] ROOT = gf4k_pow(i);
    logic [11:0] syn_q, syn_d;

    assign syn_d = gf4k_mul(start ? 12'h000 : syn_q, ROOT) ^ feed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    syn_q <= '0;
      else if (take) syn_q <= syn_d;
    end

    assign syn_words[16*i +: 16] = {4'h0, syn_q};
    assign nz_bits[i] = |syn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= sym_valid & sym_last;
  end

  assign nonzero = |nz_bits;

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_last) |=> done);

  // R7
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_valid && sym_last) |=> !done);

  // R5
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sym_valid) |=> (syn_words == '0 && !nonzero));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !sym_valid) |=> $stable(syn_words));

  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sym_valid) |=> (syn_words[11:0] == $past(sym_data)));

endmodule

// File: tb/gf4k_syndrome_gen_tb.sv
module gf4k_syndrome_gen_tb_top;
  localparam int NSYN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sym_valid = 1'b0, sym_last = 1'b0;
  logic [11:0] sym_data = '0;
  logic done, nonzero;
  logic [NSYN*16-1:0] syn_words;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gf4k_syndrome_gen #(.NSYN(NSYN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sym_valid(sym_valid),
    .sym_last(sym_last), .sym_data(sym_data), .done(done),
    .nonzero(nonzero), .syn_words(syn_words)
  );

  // polynomial product then reduction by x^6+x+1
  function automatic logic [5:0] r64(input logic [5:0] a, input logic [5:0] b);
    logic [10:0] p;
    p = '0;
    for (int k = 0; k < 6; k++) if (b[k]) p = p ^ (11'(a) << k);
    for (int k = 10; k >= 6; k--) if (p[k]) p = p ^ (11'h43 << (k - 6));
    return p[5:0];
  endfunction

  function automatic logic [11:0] r4k(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] m;
    m = r64(a[5:0], b[5:0]);
    return {r64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m,
            r64(6'h21, r64(a[11:6], b[11:6])) ^ m};
  endfunction

  logic [11:0] roots [NSYN];
  logic [11:0] expv  [NSYN];

  function automatic logic [NSYN*16-1:0] pack_exp();
    logic [NSYN*16-1:0] w;
    for (int i = 0; i < NSYN; i++) w[16*i +: 16] = {4'h0, expv[i]};
    return w;
  endfunction

  function automatic bit exp_nz();
    for (int i = 0; i < NSYN; i++) if (expv[i] != 0) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input logic [NSYN*16-1:0] act, input logic [NSYN*16-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic v, input logic l, input logic [11:0] d);
    @(negedge clk);
    start = st; sym_valid = v; sym_last = l; sym_data = d;
  endtask

  task automatic model_sym(input logic st, input logic [11:0] d);
    for (int i = 0; i < NSYN; i++) expv[i] = r4k(st ? 12'h000 : expv[i], roots[i]) ^ d;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    roots[0] = 12'h001;
    for (int i = 1; i < NSYN; i++) roots[i] = r4k(roots[i-1], 12'h0E01);
    for (int i = 0; i < NSYN; i++) expv[i] = '0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 syn", syn_words, '0);
    check("R1 done", done, 0);
    check("R1 nonzero", nonzero, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R9: every symbol value against every root
    for (int s = 0; s < 4096; s++) begin
      drive(1, 1, 0, 12'(s));
      drive(0, 1, 1, 12'h000);
      drive(0, 0, 0, 12'h000);
      for (int i = 0; i < NSYN; i++) expv[i] = r4k(12'(s), roots[i]);
      check("R3 R4 R9 products", syn_words, pack_exp());
      check("R7 done", done, 1);
      check("R8 nonzero", nonzero, (s != 0));
    end
    @(negedge clk);
    check("R7 single pulse", done, 0);

    // R6 R4: longer codeword with idle gaps
    for (int k = 0; k < 12; k++) begin
      logic [11:0] d = 12'((k * 12'h5A7 + 12'h1F3) & 12'hFFF);
      drive(k == 0, 1, k == 11, d);
      model_sym(k == 0, d);
      if (k % 3 == 1 && k != 11) begin
        drive(0, 0, 0, 12'hABC);
        drive(0, 0, 0, 12'hABC);
        check("R6 idle hold", syn_words, pack_exp());
        check("R7 no done mid", done, 0);
      end
    end
    drive(0, 0, 0, 12'h000);
    check("R4 horner", syn_words, pack_exp());
    check("R7 done", done, 1);
    check("R8 nonzero", nonzero, exp_nz());

    // R5: start alone in mid-codeword clears
    drive(1, 1, 0, 12'h123);
    drive(0, 1, 0, 12'h456);
    drive(1, 0, 0, 12'h000);
    drive(0, 0, 0, 12'h000);
    for (int i = 0; i < NSYN; i++) expv[i] = '0;
    check("R5 start clears", syn_words, pack_exp());
    check("R8 zero flag", nonzero, 0);
    check("R7 no done", done, 0);

    // R5: start with symbol restarts a running codeword
    drive(1, 1, 0, 12'h777);
    drive(0, 1, 0, 12'h0F0);
    drive(1, 1, 0, 12'h9A5);
    drive(0, 1, 1, 12'h03C);
    drive(0, 0, 0, 12'h000);
    model_sym(1, 12'h9A5);
    model_sym(0, 12'h03C);
    check("R5 restart", syn_words, pack_exp());
    check("R7 done", done, 1);

    // R8: all-zero codeword
    drive(1, 1, 0, 12'h000);
    drive(0, 1, 1, 12'h000);
    drive(0, 0, 0, 12'h000);
    check("R8 zero codeword", nonzero, 0);
    check("R7 done", done, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule